// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a processor core and offers the core one interrupt at a time. There are two groups of requests. Nine peripheral event sources arrive as level flags: external 0, timer 0, external 1, timer 1, timer 2, serial 0 receive, serial 0 transmit, serial 1 receive and serial 1 transmit. Seven software requests are held in a register inside the block. Each event source has a 3-bit priority code. The block turns that code into a 4-bit effective level that always lies above every software level. Software request n runs at the fixed level n.

On each cycle a combinational arbiter finds the strongest eligible request. It compares levels first and breaks ties with a fixed source ranking. When the output stage is idle, it captures the winner, but only if the winner's level is strictly greater than the core's current execution priority. The captured request leaves the block on a valid/ready handshake. `irq_valid` rises with a vector and a level. Once it is high, vector and level stay frozen until the core asserts `irq_ready`, which may be held low for any number of cycles. In the cycle where valid and ready are both high, the block does two things. For an event, it drives a one-cycle `evt_clr` pulse that the peripheral uses to drop its flag. For a software request, it clears the winning request bit itself. Valid then falls for at least one cycle, so the cleared flag cannot be offered again.

A byte-wide register port (write strobe, 4-bit address, combinational read data) holds the priority codes, the enables and the software requests.

Top module: `ivc_top`

## Requirements
- R1: After reset every register reads 0 at addresses 0 to 9 and `irq_valid` is low. Nothing is requested until software programs enables and codes.
- R2: An event source is eligible only when four things are true: its flag is high, its individual enable is 1, the global enable is 1, and its priority code is nonzero. Individual enables are bits 7:0 of address 6 for sources 0 to 7 and bit 0 of address 7 for source 8. The global enable is bit 7 of address 7.
- R3: An event with code c, where c is 1 to 7, is offered at level 8+c. Code 0 never produces a request.
- R4: Priority codes occupy bits 2:0 and 6:4 of these registers: address 0 holds sources 0 and 1, address 1 holds sources 2 and 3, address 2 bits 2:0 hold source 4, address 4 holds sources 5 and 6, and address 5 holds sources 7 and 8.
- R5: The highest level wins. Among equal levels, the lower source number wins. Source numbers run 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = timer 2, 5 = serial 0 receive, 6 = serial 0 transmit, 7 = serial 1 receive, 8 = serial 1 transmit.
- R6: Event vectors are 0x80 + 4·i for sources 0 to 4 and 0xA0 + 4·(i−5) for sources 5 to 8.
- R7: Software request n (1 to 7) sits at bit n of address 9 and is enabled by bit n of address 8. It is offered at level n with vector 0x100 + 4·(n−1), below any eligible event.
- R8: A winner is offered only when its level is strictly greater than `cur_prio` at the capture edge.
- R9: While `irq_valid` is high and `irq_ready` is low, `irq_valid`, `irq_vector` and `irq_level` hold unchanged, even if a stronger request arrives.
- R10: In a cycle with `irq_valid` and `irq_ready` both high, `evt_clr` pulses only the winning event's bit, or the winning software request bit is cleared. `irq_valid` is low in the following cycle.
- R11: When a register write to address 9 coincides with the acknowledge of a software request, the acknowledged bit ends cleared and the other written bits are kept.
- R12: Unimplemented register bits, and address 3, read as 0. Every implemented bit reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 9 | Event request flags, bit i = source i |
| evt_clr | output | 9 | One-cycle flag clear pulse for the acknowledged source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| cur_prio | input | 4 | Current execution priority of the core |
| irq_valid | output | 1 | Interrupt offered |
| irq_ready | input | 1 | Core accepts the offered interrupt |
| irq_vector | output | 16 | Vector address of the offered interrupt |
| irq_level | output | 4 | Level of the offered interrupt |

## Verification
Two functions can land in the same cycle: the acknowledge that clears a software request bit, and a software write to that same request register. The bench provokes this by raising `irq_ready` on the same cycle that it writes address 9 with both the acknowledged bit and another bit set. It then judges the outcome by reading the register back and by checking that the next vector offered belongs to the surviving bit. A second overlap is a stronger event that arrives while an offer is stalled by `irq_ready`. There the bench checks that the pending offer stays frozen and that the newcomer appears only after the acknowledge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int N_EVT  = 9;
  localparam int N_SW   = 7;
  localparam int CODE_W = 3;
  localparam int LVL_W  = CODE_W + 1;
  localparam int VEC_W  = 16;
  localparam int N_SRC  = N_EVT + N_SW;
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int DATA_W = 8;

  localparam int A_EN_LO  = 6;
  localparam int A_EN_HI  = 7;
  localparam int A_SW_EN  = 8;
  localparam int A_SW_REQ = 9;
  localparam int GLB_BIT  = 7;

  // register holding the priority code of event source i
  function automatic int prio_addr(input int i);
    if (i < 4)       return i / 2;
    else if (i == 4) return 2;
    else             return 4 + (i - 5) / 2;
  endfunction

  // bit offset of that code inside its register
  function automatic int prio_shift(input int i);
    if (i < 4)       return (i % 2) * 4;
    else if (i == 4) return 0;
    else             return ((i - 5) % 2) * 4;
  endfunction

  function automatic logic [VEC_W-1:0] evt_vector(input int i);
    if (i < 5) return VEC_W'(32'h80 + 4 * i);
    else       return VEC_W'(32'hA0 + 4 * (i - 5));
  endfunction

  function automatic logic [VEC_W-1:0] sw_vector(input int n);
    return VEC_W'(32'h100 + 4 * (n - 1));
  endfunction
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  logic [N_SW:1]                sw_clr,
  output logic [N_EVT-1:0][CODE_W-1:0] codes,
  output logic [N_EVT-1:0]             evt_en,
  output logic                         glb_en,
  output logic [N_SW:1]                sw_en,
  output logic [N_SW:1]                sw_req
);
  logic [N_SW:1] sw_req_wr;

  assign sw_req_wr = (we && addr == ADDR_W'(A_SW_REQ)) ? wdata[N_SW:1] : sw_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codes  <= '0;
      evt_en <= '0;
      glb_en <= 1'b0;
      sw_en  <= '0;
      sw_req <= '0;
    end else begin
      if (we) begin
        for (int i = 0; i < N_EVT; i++) begin
          if (addr == ADDR_W'(prio_addr(i)))
            codes[i] <= wdata[prio_shift(i) +: CODE_W];
          if (i < 8 && addr == ADDR_W'(A_EN_LO))
            evt_en[i] <= wdata[i % 8];
          if (i >= 8 && addr == ADDR_W'(A_EN_HI))
            evt_en[i] <= wdata[i % 8];
        end
        if (addr == ADDR_W'(A_EN_HI)) glb_en <= wdata[GLB_BIT];
        if (addr == ADDR_W'(A_SW_EN)) sw_en  <= wdata[N_SW:1];
      end
      // an acknowledge clear beats a same-cycle write of the same bit
      sw_req <= sw_req_wr & ~sw_clr;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_EVT; i++) begin
      if (addr == ADDR_W'(prio_addr(i)))
        rdata[prio_shift(i) +: CODE_W] = codes[i];
      if (i < 8 && addr == ADDR_W'(A_EN_LO))
        rdata[i % 8] = evt_en[i];
      if (i >= 8 && addr == ADDR_W'(A_EN_HI))
        rdata[i % 8] = evt_en[i];
    end
    if (addr == ADDR_W'(A_EN_HI))  rdata[GLB_BIT] = glb_en;
    if (addr == ADDR_W'(A_SW_EN))  rdata[N_SW:1]  = sw_en;
    if (addr == ADDR_W'(A_SW_REQ)) rdata[N_SW:1]  = sw_req;
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
(
  input  logic [N_EVT-1:0]             evt_req,
  input  logic [N_EVT-1:0][CODE_W-1:0] codes,
  input  logic [N_EVT-1:0]             evt_en,
  input  logic                         glb_en,
  input  logic [N_SW:1]                sw_en,
  input  logic [N_SW:1]                sw_req,
  output logic                         any,
  output logic [IDX_W-1:0]             win_idx,
  output logic [LVL_W-1:0]             win_lvl,
  output logic [VEC_W-1:0]             win_vec
);
  logic [N_SRC-1:0]            elig;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [N_SRC-1:0][VEC_W-1:0] vec;

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    assign elig[g] = evt_req[g] & evt_en[g] & glb_en & (|codes[g]);
    assign lvl[g]  = {1'b1, codes[g]};
    assign vec[g]  = evt_vector(g);
  end

  for (genvar n = 1; n <= N_SW; n++) begin : g_sw
    assign elig[N_EVT-1+n] = sw_req[n] & sw_en[n];
    assign lvl[N_EVT-1+n]  = LVL_W'(n);
    assign vec[N_EVT-1+n]  = sw_vector(n);
  end

  // ascending scan with strict compare: ties keep the lower index
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    win_vec = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (elig[s] && (!any || lvl[s] > win_lvl)) begin
        any     = 1'b1;
        win_idx = IDX_W'(s);
        win_lvl = lvl[s];
        win_vec = vec[s];
      end
    end
  end
endmodule

// File: rtl/ivc_present.sv
module ivc_present
  import ivc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [VEC_W-1:0] win_vec,
  input  logic [LVL_W-1:0] cur_prio,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vector,
  output logic [LVL_W-1:0] level,
  output logic [N_EVT-1:0] evt_clr,
  output logic [N_SW:1]    sw_clr
);
  logic             take;
  logic             ack;
  logic [IDX_W-1:0] idx_q;

  assign take = any && (win_lvl > cur_prio);
  assign ack  = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      vector <= '0;
      level  <= '0;
      idx_q  <= '0;
    end else if (valid) begin
      if (ready) valid <= 1'b0;
    end else begin
      valid <= take;
      if (take) begin
        vector <= win_vec;
        level  <= win_lvl;
        idx_q  <= win_idx;
      end
    end
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_eclr
    assign evt_clr[g] = ack && (idx_q == IDX_W'(g));
  end

  for (genvar n = 1; n <= N_SW; n++) begin : g_sclr
    assign sw_clr[n] = ack && (idx_q == IDX_W'(N_EVT - 1 + n));
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_req,
  output logic [N_EVT-1:0]  evt_clr,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  cur_prio,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector,
  output logic [LVL_W-1:0]  irq_level
);
  logic [N_EVT-1:0][CODE_W-1:0] codes;
  logic [N_EVT-1:0]             evt_en;
  logic                         glb_en;
  logic [N_SW:1]                sw_en;
  logic [N_SW:1]                sw_req;
  logic [N_SW:1]                sw_clr;
  logic                         any;
  logic [IDX_W-1:0]             win_idx;
  logic [LVL_W-1:0]             win_lvl;
  logic [VEC_W-1:0]             win_vec;

  ivc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .sw_clr(sw_clr),
    .codes(codes), .evt_en(evt_en), .glb_en(glb_en),
    .sw_en(sw_en), .sw_req(sw_req)
  );

  ivc_arbiter u_arb (
    .evt_req(evt_req), .codes(codes), .evt_en(evt_en), .glb_en(glb_en),
    .sw_en(sw_en), .sw_req(sw_req), .any(any), .win_idx(win_idx),
    .win_lvl(win_lvl), .win_vec(win_vec)
  );

  ivc_present u_pres (
    .clk(clk), .rst_n(rst_n), .any(any), .win_idx(win_idx),
    .win_lvl(win_lvl), .win_vec(win_vec), .cur_prio(cur_prio),
    .ready(irq_ready), .valid(irq_valid), .vector(irq_vector),
    .level(irq_level), .evt_clr(evt_clr), .sw_clr(sw_clr)
  );
endmodule

// File: rtl/ivc_top_sva.sv
module ivc_top_sva
  import ivc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_clr,
  input logic [LVL_W-1:0] cur_prio,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [VEC_W-1:0] irq_vector,
  input logic [LVL_W-1:0] irq_level
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vector) && $stable(irq_level))); // R9
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid); // R10
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_clr)); // R10
  AST_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_clr) |-> (irq_valid && irq_ready)); // R10
  AST_ABOVE_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> (irq_level > $past(cur_prio))); // R8
  AST_EVENT_VECTOR_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level[LVL_W-1]) |-> (irq_vector >= 16'h80 && irq_vector <= 16'hAC)); // R6
  AST_SW_VECTOR_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_level[LVL_W-1]) |-> (irq_level != 0 && irq_vector[15:8] == 8'h01)); // R7
endmodule

bind ivc_top ivc_top_sva u_sva (
  .clk(clk), .rst_n(rst_n), .evt_clr(evt_clr), .cur_prio(cur_prio),
  .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
  .irq_level(irq_level)
);

// File: tb/ivc_top_test.sv
module ivc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  evt_req;
  logic [8:0]  evt_clr;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  cur_prio = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [15:0] irq_vector;
  logic [3:0]  irq_level;

  logic [8:0]  flag_set = '0;
  logic [8:0]  flag_kill = '0;
  logic [8:0]  flags = '0;
  int          code_sh [9];
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  ivc_top uut (
    .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .evt_clr(evt_clr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cur_prio(cur_prio), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .irq_level(irq_level)
  );

  // peripheral flag model: set pulses raise, clear pulse or kill drops
  always @(posedge clk) flags <= (flags & ~evt_clr & ~flag_kill) | flag_set;
  assign evt_req = flags;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic write_codes();
    wr(0, code_sh[0] | (code_sh[1] << 4));
    wr(1, code_sh[2] | (code_sh[3] << 4));
    wr(2, code_sh[4]);
    wr(4, code_sh[5] | (code_sh[6] << 4));
    wr(5, code_sh[7] | (code_sh[8] << 4));
  endtask

  task automatic raise(input logic [8:0] m);
    @(negedge clk); flag_set = m;
    @(negedge clk); flag_set = '0;
    @(negedge clk);
  endtask

  task automatic kill_all();
    @(negedge clk); flag_kill = '1;
    @(negedge clk); flag_kill = '0;
  endtask

  // acknowledge; returns clear pulse seen in the ack cycle
  task automatic ack(output int clr);
    @(negedge clk); irq_ready = 1'b1;
    #1 clr = int'(evt_clr);
    @(negedge clk); irq_ready = 1'b0;
  endtask

  function automatic int exp_vec(input int i);
    return (i < 5) ? (32'h80 + 4 * i) : (32'hA0 + 4 * (i - 5));
  endfunction

  // bench winner among pending flags (all enables on): -1 if none
  function automatic int exp_win();
    int best = -1; int bl = 0;
    for (int i = 0; i < 9; i++)
      if (flags[i] && code_sh[i] != 0 && 8 + code_sh[i] > bl) begin
        best = i; bl = 8 + code_sh[i];
      end
    return best;
  endfunction

  initial begin
    int d; int clr; int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid after reset", int'(irq_valid), 0);
    for (int a = 0; a < 10; a++) begin
      rd(a, d); chk("R1 register reset", d, 0);
    end
    raise(9'h1FF);
    repeat (2) @(negedge clk);
    chk("R1 no request when unprogrammed", int'(irq_valid), 0);
    kill_all();

    // R12 read-back masks
    for (int p = 0; p < 2; p++) begin
      int pat = (p == 0) ? 8'hFF : 8'hA5;
      int mask [10] = '{8'h77, 8'h77, 8'h07, 8'h00, 8'h77, 8'h77, 8'hFF, 8'h81, 8'hFE, 8'hFE};
      for (int a = 0; a < 10; a++) begin
        wr(a, pat); rd(a, d); chk("R12 readback", d, pat & mask[a]);
        wr(a, 0);
      end
    end

    // R2 gating by global and individual enable
    for (int i = 0; i < 9; i++) begin
      for (int k = 0; k < 9; k++) code_sh[k] = 0;
      code_sh[i] = 3;
      write_codes();
      wr(6, 8'hFF); wr(7, 8'h01);
      raise(9'(1 << i)); @(negedge clk);
      chk("R2 global enable off", int'(irq_valid), 0);
      kill_all();
      wr(6, (i < 8) ? (8'hFF & ~(1 << i)) : 8'hFF);
      wr(7, (i == 8) ? 8'h80 : 8'h81);
      raise(9'(1 << i)); @(negedge clk);
      chk("R2 individual enable off", int'(irq_valid), 0);
      kill_all();
    end

    // R3 R4 R6 R10: every source, every code
    wr(6, 8'hFF); wr(7, 8'h81);
    for (int i = 0; i < 9; i++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 9; k++) code_sh[k] = 0;
        code_sh[i] = c;
        write_codes();
        raise(9'(1 << i)); @(negedge clk);
        chk("R3 valid vs code", int'(irq_valid), (c != 0) ? 1 : 0);
        if (c != 0) begin
          chk("R3 level", int'(irq_level), 8 + c);
          chk("R6 vector", int'(irq_vector), exp_vec(i));
          ack(clr);
          chk("R10 clear pulse", clr, 1 << i);
          chk("R10 valid drops", int'(irq_valid), 0);
          #1 chk("R10 flag cleared", int'(flags[i]), 0);
        end else kill_all();
      end
    end

    // R8 threshold sweep
    for (int c = 1; c < 8; c++) begin
      for (int k = 0; k < 9; k++) code_sh[k] = 0;
      code_sh[0] = c;
      write_codes();
      for (int cp = 0; cp < 16; cp++) begin
        @(negedge clk); cur_prio = 4'(cp);
        raise(9'h001); @(negedge clk);
        chk("R8 strict threshold", int'(irq_valid), (8 + c > cp) ? 1 : 0);
        if (irq_valid) ack(clr); else kill_all();
      end
    end
    @(negedge clk); cur_prio = '0;

    // R5 arbitration: drain mixed patterns
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 9; k++) code_sh[k] = (p == 0) ? 5 : ((k * p + p) % 8);
      write_codes();
      raise(9'h1FF); @(negedge clk);
      for (int n = 0; n < 9; n++) begin
        w = exp_win();
        if (w < 0) begin
          chk("R5 none left", int'(irq_valid), 0);
          break;
        end
        chk("R5 winner vector", int'(irq_vector), exp_vec(w));
        chk("R5 winner level", int'(irq_level), 8 + code_sh[w]);
        ack(clr);
        @(negedge clk);
      end
      kill_all();
    end

    // R9 hold while stalled
    for (int k = 0; k < 9; k++) code_sh[k] = 0;
    code_sh[5] = 2; code_sh[0] = 7;
    write_codes();
    raise(9'h020); @(negedge clk);
    chk("R9 first offer", int'(irq_vector), 32'hA0);
    raise(9'h001); repeat (3) @(negedge clk);
    chk("R9 vector held", int'(irq_vector), 32'hA0);
    chk("R9 level held", int'(irq_level), 10);
    chk("R9 still valid", int'(irq_valid), 1);
    ack(clr);
    chk("R10 clears stalled winner", clr, 9'h020);
    @(negedge clk);
    chk("R9 newcomer after ack", int'(irq_vector), 32'h80);
    chk("R9 newcomer level", int'(irq_level), 15);
    ack(clr);

    // R7 software requests
    wr(8, 8'hFE);
    for (int n = 1; n < 8; n++) begin
      wr(9, 1 << n); @(negedge clk);
      chk("R7 sw valid", int'(irq_valid), 1);
      chk("R7 sw vector", int'(irq_vector), 32'h100 + 4 * (n - 1));
      chk("R7 sw level", int'(irq_level), n);
      ack(clr);
      chk("R10 sw no event clear", clr, 0);
      rd(9, d); chk("R10 sw bit cleared", d, 0);
    end
    wr(8, 0); wr(9, 8'h10); repeat (2) @(negedge clk);
    chk("R7 sw disabled", int'(irq_valid), 0);
    rd(9, d); chk("R7 sw request kept", d, 8'h10);
    wr(9, 0);

    // R7 events above software
    wr(8, 8'hFE);
    for (int k = 0; k < 9; k++) code_sh[k] = 0;
    code_sh[8] = 1; write_codes();
    raise(9'h100);
    wr(9, 8'h80); @(negedge clk);
    chk("R7 event beats sw", int'(irq_vector), 32'hAC);
    ack(clr);
    @(negedge clk);
    chk("R7 sw after event", int'(irq_vector), 32'h118);
    chk("R7 sw7 level", int'(irq_level), 7);
    ack(clr);

    // R11 write colliding with ack
    wr(9, 8'h08); @(negedge clk);
    chk("R11 sw3 offered", int'(irq_vector), 32'h108);
    @(negedge clk);
    irq_ready = 1'b1; reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 8'h28;
    @(negedge clk);
    irq_ready = 1'b0; reg_we = 1'b0;
    rd(9, d); chk("R11 acked bit cleared over write", d, 8'h20);
    chk("R11 next is sw5", int'(irq_vector), 32'h110);
    ack(clr);
    rd(9, d); chk("R11 all clear", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule